// File: doc/BRIEF.md
# Constant Bit-Slip Word Aligner

This block moves the word boundaries of a parallel data stream by a fixed number of bit positions, chosen when the design is built. Each clock brings one word of `WIDTH` bits. Bit 0 of a word is the earliest bit in the stream, and bit `WIDTH-1` is the latest. The aligner emits a word of the same width. That word starts `SLIP` bit positions earlier in the stream than the word now arriving. Its high part comes from the low bits of the current input, and its low part comes from the top bits of the words that came before.

Typical use is behind a deserializer whose word boundary sits at a known, constant offset from the wanted framing. `HIST` sets how many earlier words the slip may reach into, so a slip can span more than one word. `REG_OUT` chooses between a combinational output and a registered output that adds one clock of latency.

Top module: `slip_aligner`

## Requirements
- R1: With `REG_OUT`=0, output bit j during the cycle that carries input word n equals stream bit n*`WIDTH`+j-`SLIP`, where stream bit n*`WIDTH`+i is bit i of word n and positions before the first word after reset read 0.
- R2: With `SLIP`=0 and `REG_OUT`=0, the output equals the current input word unchanged.
- R3: For 0<`SLIP`<=`WIDTH`, the low `SLIP` output bits are the top `SLIP` bits of the previous input word, placed in the same order.
- R4: Width 4, input 4'b0011 for one cycle followed by zeros, combinational output: slip 0 gives 0011 then 0000; slip 1 gives 0110 then 0000; slip 2 gives 1100 then 0000; slip 3 gives 1000 then 0001.
- R5: With `REG_OUT`=1, the output in each cycle equals the value the combinational form would have shown one cycle earlier.
- R6: With `REG_OUT`=0, once reset is released and before any nonzero word arrives, the output reads 0.
- R7: A synchronous active-high reset clears all stored history and the output register. After reset, the block behaves as if every earlier word were zero.
- R8: When `SLIP` is larger than `WIDTH` (within `HIST`*`WIDTH`-1), output bits come from words up to `HIST` cycles old, following the same stream-position rule as R1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| din | input | WIDTH | Incoming word, bit 0 earliest |
| dout | output | WIDTH | Realigned word |

## Verification
The bench focuses on carry across the word boundary. A lone 0011 word is driven through every slip of a 4-bit aligner, and slip 3 must show a 0001 in the following cycle. A design that took bits from the wrong end of the previous word, or forgot them, would show a wrong or missing tail. A second aligner uses a slip of 11 on 8-bit words, which reaches two words back. An off-by-one in how far the history extends would move those bits by a whole word. A reset in the middle of the run, driven while the input is all ones, checks that no stale bits leak into the first words afterwards. The registered and combinational variants run side by side, so a latency error of one cycle in either variant shows up on every word.

// File: rtl/bslip_pkg.sv
package bslip_pkg;

  // A slip is legal when it lies inside the reachable history.
  function automatic bit slip_ok(input int w, input int h, input int s);
    return (w > 0) && (h > 0) && (s >= 0) && (s < h * w);
  endfunction

  // Number of fresh input bits the history has to retain each cycle.
  function automatic int carry_in_bits(input int w, input int s);
    return (s < w) ? s : w;
  endfunction

endpackage

// File: rtl/bslip_carry.sv
module bslip_carry #(
  parameter int WIDTH = 8,
  parameter int SLIP  = 3,
  localparam int IN_W = bslip_pkg::carry_in_bits(WIDTH, SLIP)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [IN_W-1:0] top_bits,
  output logic [SLIP-1:0] carry_q
);

  // Only the last SLIP stream bits are ever shown again, so only they are kept.
  if (SLIP <= WIDTH) begin : g_short
    always_ff @(posedge clk) begin
      if (rst) carry_q <= '0;
      else     carry_q <= top_bits;
    end
  end else begin : g_long
    always_ff @(posedge clk) begin
      if (rst) carry_q <= '0;
      else     carry_q <= {top_bits, carry_q[SLIP-1:WIDTH]};
    end
  end

  logic run_q = 1'b0;
  always_ff @(posedge clk) run_q <= !rst;

  AST_CARRY_LOAD: assert property (@(posedge clk) disable iff (rst)
    run_q |-> carry_q[SLIP-1 -: IN_W] == $past(top_bits)); // R3

endmodule

// File: rtl/bslip_join.sv
module bslip_join #(
  parameter int WIDTH = 8,
  parameter int SLIP  = 3
) (
  input  logic [WIDTH-SLIP-1:0] cur_low,
  input  logic [SLIP-1:0]       carry,
  output logic [WIDTH-1:0]      word_o
);

  // Older bits sit at the bottom, fresh bits above them.
  always_comb word_o = {cur_low, carry};

endmodule

// File: rtl/slip_aligner.sv
module slip_aligner #(
  parameter int WIDTH   = 8,
  parameter int SLIP    = 3,
  parameter int HIST    = 1,
  parameter bit REG_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  if (!bslip_pkg::slip_ok(WIDTH, HIST, SLIP)) begin : g_bad_slip
    $error("slip_aligner: SLIP must be within 0 .. HIST*WIDTH-1");
  end

  localparam int IN_W = bslip_pkg::carry_in_bits(WIDTH, SLIP);

  logic [WIDTH-1:0] aligned;

  if (SLIP == 0) begin : g_pass
    always_comb aligned = din;
  end else if (SLIP < WIDTH) begin : g_mix
    logic [SLIP-1:0] carry_q;
    bslip_carry #(.WIDTH(WIDTH), .SLIP(SLIP)) u_carry (
      .clk(clk), .rst(rst), .top_bits(din[WIDTH-1 -: IN_W]), .carry_q(carry_q));
    bslip_join #(.WIDTH(WIDTH), .SLIP(SLIP)) u_join (
      .cur_low(din[WIDTH-SLIP-1:0]), .carry(carry_q), .word_o(aligned));
  end else begin : g_deep
    logic [SLIP-1:0] carry_q;
    bslip_carry #(.WIDTH(WIDTH), .SLIP(SLIP)) u_carry (
      .clk(clk), .rst(rst), .top_bits(din[WIDTH-1 -: IN_W]), .carry_q(carry_q));
    always_comb aligned = carry_q[WIDTH-1:0];
  end

  if (REG_OUT) begin : g_reg
    logic [WIDTH-1:0] out_q;
    always_ff @(posedge clk) begin
      if (rst) out_q <= '0;
      else     out_q <= aligned;
    end
    assign dout = out_q;

    logic rst_q  = 1'b0;
    logic run_q  = 1'b0;
    logic run2_q = 1'b0;
    always_ff @(posedge clk) begin
      rst_q  <= rst;
      run_q  <= !rst;
      run2_q <= run_q;
    end

    AST_RST_CLEAR: assert property (@(posedge clk) disable iff (rst)
      rst_q |-> dout == '0); // R7

    if (SLIP < WIDTH) begin : g_chk_upper
      AST_REG_UPPER: assert property (@(posedge clk) disable iff (rst)
        run_q |-> dout[WIDTH-1:SLIP] == $past(din[WIDTH-1-SLIP:0])); // R5
    end

    if (SLIP > 0 && SLIP <= WIDTH) begin : g_chk_carry
      AST_REG_CARRY: assert property (@(posedge clk) disable iff (rst)
        (run_q && run2_q) |-> dout[SLIP-1:0] == $past(din[WIDTH-1 -: SLIP], 2)); // R3
    end
  end else begin : g_comb
    assign dout = aligned;

    if (SLIP < WIDTH) begin : g_chk_upper
      AST_COMB_UPPER: assert property (@(posedge clk) disable iff (rst)
        dout[WIDTH-1:SLIP] == din[WIDTH-1-SLIP:0]); // R1
    end

    if (SLIP > 0 && SLIP <= WIDTH) begin : g_chk_carry
      logic run_q = 1'b0;
      always_ff @(posedge clk) run_q <= !rst;
      AST_COMB_CARRY: assert property (@(posedge clk) disable iff (rst)
        run_q |-> dout[SLIP-1:0] == $past(din[WIDTH-1 -: SLIP])); // R3
    end
  end

endmodule

// File: tb/sim_slip_aligner.sv
`timescale 1ns/1ps
module sim_slip_aligner;

  localparam int CLK_NS = 20;

  logic clk = 1'b0;
  always #(CLK_NS/2) clk = ~clk;

  logic       rst  = 1'b1;
  logic [3:0] din4 = '0;
  logic [7:0] din8 = '0;
  logic [7:0] d8;
  logic [3:0] d4 [4][2];

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic [3:0] q4[$];
  logic [7:0] q8[$];

  slip_aligner #(.WIDTH(8), .SLIP(11), .HIST(2), .REG_OUT(1'b1)) u0 (
    .clk(clk), .rst(rst), .din(din8), .dout(d8));

  for (genvar gs = 0; gs < 4; gs++) begin : g_s
    for (genvar gr = 0; gr < 2; gr++) begin : g_r
      slip_aligner #(.WIDTH(4), .SLIP(gs), .HIST(1), .REG_OUT(gr == 1)) u_a (
        .clk(clk), .rst(rst), .din(din4), .dout(d4[gs][gr]));
    end
  end

  // Stream model: output word n starts at stream bit n*w - s.
  function automatic logic [7:0] ref_word(input int w, input int s, input int n);
    logic [7:0] r;
    r = '0;
    for (int j = 0; j < w; j++) begin
      int pos;
      pos = n * w + j - s;
      if (n >= 0 && pos >= 0) begin
        if (w == 8) r[j] = q8[pos / 8][pos % 8];
        else        r[j] = q4[pos / 4][pos % 4];
      end
    end
    return r;
  endfunction

  task automatic expect_eq(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all();
    int n;
    n = q4.size() - 1;
    for (int s = 0; s < 4; s++) begin
      for (int r = 0; r < 2; r++) begin
        string tag;
        tag = (r == 1) ? "R5" : ((s == 0) ? "R2" : "R1");
        expect_eq(tag, {4'b0, d4[s][r]}, ref_word(4, s, (r == 1) ? n - 1 : n));
      end
      if (s > 0 && n >= 1) begin
        logic [3:0] mask;
        mask = 4'((1 << s) - 1);
        expect_eq("R3", {4'b0, d4[s][0] & mask}, {4'b0, q4[n-1] >> (4 - s)});
      end
    end
    expect_eq("R8", d8, ref_word(8, 11, n - 1));
  endtask

  task automatic step(input logic [3:0] w4, input logic [7:0] w8);
    @(posedge clk); #1;
    din4 = w4; din8 = w8;
    q4.push_back(w4); q8.push_back(w8);
    @(negedge clk);
    check_all();
  endtask

  task automatic release_reset();
    @(posedge clk); #1;
    rst = 1'b0; din4 = '0; din8 = '0;
    q4.delete(); q8.delete();
    @(negedge clk);
    for (int s = 0; s < 4; s++) begin
      expect_eq("R6", {4'b0, d4[s][0]}, 8'h00);
      expect_eq("R7", {4'b0, d4[s][1]}, 8'h00);
    end
    expect_eq("R7", d8, 8'h00);
  endtask

  task automatic hold_reset(input logic [3:0] w4, input logic [7:0] w8);
    @(posedge clk); #1;
    rst = 1'b1; din4 = w4; din8 = w8;
    repeat (2) @(posedge clk);
    @(negedge clk);
    for (int s = 0; s < 4; s++) begin
      logic [3:0] mask;
      mask = 4'((1 << s) - 1);
      expect_eq("R7", {4'b0, d4[s][1]}, 8'h00);
      expect_eq("R7", {4'b0, d4[s][0] & mask}, 8'h00);
    end
    expect_eq("R7", d8, 8'h00);
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R1 watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] lfsr;
    logic [3:0] slip_first [4];
    logic [3:0] slip_second [4];
    slip_first  = '{4'b0011, 4'b0110, 4'b1100, 4'b1000};
    slip_second = '{4'b0000, 4'b0000, 4'b0000, 4'b0001};

    hold_reset(4'h0, 8'h00);
    release_reset();

    // Worked example: single 0011 word followed by zeros (R4).
    step(4'b0011, 8'hC3);
    for (int s = 0; s < 4; s++) expect_eq("R4", {4'b0, d4[s][0]}, {4'b0, slip_first[s]});
    step(4'b0000, 8'h00);
    for (int s = 0; s < 4; s++) begin
      expect_eq("R4", {4'b0, d4[s][0]}, {4'b0, slip_second[s]});
      expect_eq("R4", {4'b0, d4[s][1]}, {4'b0, slip_first[s]});
    end
    step(4'b0000, 8'h00);
    for (int s = 0; s < 4; s++) expect_eq("R4", {4'b0, d4[s][1]}, {4'b0, slip_second[s]});
    step(4'b0000, 8'h00);

    repeat (4) step(4'hF, 8'hFF);
    for (int k = 0; k < 6; k++) step((k % 2) ? 4'h5 : 4'hA, (k % 2) ? 8'hAA : 8'h55);

    lfsr = 8'h5B;
    for (int k = 0; k < 60; k++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      step(lfsr[6:3], lfsr);
    end

    // Reset in mid stream with all ones on the input (R7).
    hold_reset(4'hF, 8'hFF);
    release_reset();
    for (int k = 0; k < 40; k++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      step(lfsr[4:1], ~lfsr);
    end

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule